// File: doc/BRIEF.md
# Software-Loaded Return Address Port

This block gives a small 4-bit processor with no call stack a way to return from subroutines and to jump to computed addresses. It holds a 12-bit program address as three 4-bit registers. Software writes them one nibble at a time through I/O port addresses 0 to 2. Touching port 3 then asks the program counter to load the stored address. The block raises a one-cycle load pulse and presents the whole 12-bit target in that same cycle.

A mode input turns on automatic capture. Each unconditional jump then copies the address of the instruction after the jump into the three registers. That makes them a single-level link register, which software can read back nibble by nibble or fire through port 3 to return. A second capture overwrites the first, so only one level of return is kept.

The program counter and the instruction decoder are outside this block. The processor tells the block when an unconditional jump executes and what the following address is.

Top module: `link_port`

## Requirements
- R1: After reset, all three nibble registers read 0, `pcLoad` is 0 and `pcTarget` is 0.
- R2: A cycle with `ioSel`=1, `ioWe`=1 and `ioAddr` of 0, 1 or 2 stores `ioWrData` into address bits 3:0, 7:4 or 11:8 respectively, from the next clock edge.
- R3: `ioRdData` shows, combinationally, the nibble selected by `ioAddr` (0 gives bits 3:0, 1 gives bits 7:4, 2 gives bits 11:8) and reads 0 for port 3. A cycle with `ioWe`=0 changes no nibble.
- R4: A cycle with `ioSel`=1 and `ioAddr`=3, read or write, makes `pcLoad` 1 in the following cycle. In that cycle `pcTarget` equals the 12-bit stored address as it was during the access. Data written to port 3 changes no nibble.
- R5: `pcLoad` is 0 in any cycle that does not follow a port 3 access, and `pcTarget` holds its value between such accesses.
- R6: With `autoEn`=1, a cycle with `jmpTaken`=1 loads all three nibbles from `retAddr` at the next edge.
- R7: With `autoEn`=0, `jmpTaken` has no effect on the stored address.
- R8: When a nibble write and an automatic capture fall in the same cycle, the written nibble takes `ioWrData` and the other nibbles take their part of `retAddr`.
- R9: Port 3 accesses in two consecutive cycles give `pcLoad` high in two consecutive cycles.
- R10: A second capture replaces the first, so only the most recent return address is held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| ioSel | input | 1 | I/O access to this block in this cycle |
| ioWe | input | 1 | The access is a write |
| ioAddr | input | 2 | Port address: 0 to 2 select a nibble, 3 is the load strobe |
| ioWrData | input | 4 | Write data nibble |
| ioRdData | output | 4 | Read-back nibble for `ioAddr` |
| autoEn | input | 1 | Enables capture on unconditional jumps |
| jmpTaken | input | 1 | An unconditional jump executes this cycle |
| retAddr | input | 12 | Address of the instruction after the jump |
| pcLoad | output | 1 | One-cycle request to load the program counter |
| pcTarget | output | 12 | Address to load, valid while `pcLoad` is 1 |

## Verification
The hardest situation to reach is a software nibble write that lands in the same cycle as an automatic capture. The processor would never do both in one cycle, so a bench driving a real program would not produce it. The stimulus drives `ioSel`/`ioWe` and `jmpTaken` together in one cycle and reads all three ports afterwards, so that a mix of written and captured nibbles is visible. Back-to-back strobes are produced the same way, by holding port 3 selected across two edges.

// File: rtl/link_pkg.sv
package link_pkg;
  localparam int NIB_W   = 4;
  localparam int NIB_CNT = 3;
  localparam int ADDR_W  = NIB_W * NIB_CNT;
  localparam int PORT_AW = $clog2(NIB_CNT + 1);

  // Strobes from the control decode to the datapath
  typedef struct packed {
    logic [NIB_CNT-1:0] nibWr;   // software write, one bit per nibble
    logic               capture; // auto-capture on an unconditional jump
    logic               fire;    // strobe port accessed
  } linkCtl_t;
endpackage

// File: rtl/link_ctrl.sv
module link_ctrl
  import link_pkg::*;
(
  input  logic               ioSel,
  input  logic               ioWe,
  input  logic [PORT_AW-1:0] ioAddr,
  input  logic               autoEn,
  input  logic               jmpTaken,
  output linkCtl_t           ctl
);
  for (genvar g = 0; g < NIB_CNT; g++) begin : gWrDec
    assign ctl.nibWr[g] = ioSel && ioWe && (ioAddr == PORT_AW'(g));
  end

  assign ctl.capture = autoEn && jmpTaken;
  assign ctl.fire    = ioSel && (ioAddr == PORT_AW'(NIB_CNT));
endmodule

// File: rtl/link_data.sv
module link_data
  import link_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  linkCtl_t           ctl,
  input  logic [NIB_W-1:0]   ioWrData,
  input  logic [ADDR_W-1:0]  retAddr,
  input  logic [PORT_AW-1:0] ioAddr,
  output logic [ADDR_W-1:0]  addrReg,
  output logic [NIB_W-1:0]   ioRdData,
  output logic               pcLoad,
  output logic [ADDR_W-1:0]  pcTarget
);
  logic [NIB_W-1:0] nibQ [NIB_CNT];

  for (genvar g = 0; g < NIB_CNT; g++) begin : gNib
    // A software write outranks a capture on the same nibble
    always_ff @(posedge clk) begin
      if (!rstN)                nibQ[g] <= '0;
      else if (ctl.nibWr[g])    nibQ[g] <= ioWrData;
      else if (ctl.capture)     nibQ[g] <= retAddr[g*NIB_W +: NIB_W];
    end
    assign addrReg[g*NIB_W +: NIB_W] = nibQ[g];
  end

  always_comb begin
    ioRdData = '0;
    for (int i = 0; i < NIB_CNT; i++) begin
      if (ioAddr == PORT_AW'(i)) ioRdData = nibQ[i];
    end
  end

  // Pulse and target change together so the PC sees one consistent value
  always_ff @(posedge clk) begin
    if (!rstN) begin
      pcLoad   <= 1'b0;
      pcTarget <= '0;
    end else begin
      pcLoad <= ctl.fire;
      if (ctl.fire) pcTarget <= addrReg;
    end
  end
endmodule

// File: rtl/link_port.sv
module link_port
  import link_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               ioSel,
  input  logic               ioWe,
  input  logic [PORT_AW-1:0] ioAddr,
  input  logic [NIB_W-1:0]   ioWrData,
  output logic [NIB_W-1:0]   ioRdData,
  input  logic               autoEn,
  input  logic               jmpTaken,
  input  logic [ADDR_W-1:0]  retAddr,
  output logic               pcLoad,
  output logic [ADDR_W-1:0]  pcTarget
);
  linkCtl_t          ctl;
  logic [ADDR_W-1:0] addrReg;

  link_ctrl u_ctrl (
    .ioSel    (ioSel),
    .ioWe     (ioWe),
    .ioAddr   (ioAddr),
    .autoEn   (autoEn),
    .jmpTaken (jmpTaken),
    .ctl      (ctl)
  );

  link_data u_data (
    .clk      (clk),
    .rstN     (rstN),
    .ctl      (ctl),
    .ioWrData (ioWrData),
    .retAddr  (retAddr),
    .ioAddr   (ioAddr),
    .addrReg  (addrReg),
    .ioRdData (ioRdData),
    .pcLoad   (pcLoad),
    .pcTarget (pcTarget)
  );
endmodule

// File: rtl/link_port_chk.sv
module link_port_chk
  import link_pkg::*;
(
  input logic               clk,
  input logic               rstN,
  input logic               ioSel,
  input logic               ioWe,
  input logic [PORT_AW-1:0] ioAddr,
  input logic [NIB_W-1:0]   ioWrData,
  input logic               autoEn,
  input logic               jmpTaken,
  input logic [ADDR_W-1:0]  retAddr,
  input logic               pcLoad,
  input logic [ADDR_W-1:0]  pcTarget,
  input logic [ADDR_W-1:0]  addrReg
);
  logic strobeAcc, nibWrAcc;
  assign strobeAcc = ioSel && (ioAddr == PORT_AW'(NIB_CNT));
  assign nibWrAcc  = ioSel && ioWe && (ioAddr != PORT_AW'(NIB_CNT));

  assert_pulse_R4: assert property (@(posedge clk) disable iff (!rstN)
    strobeAcc |=> pcLoad);

  assert_target_R4: assert property (@(posedge clk) disable iff (!rstN)
    strobeAcc |=> pcTarget == $past(addrReg));

  assert_no_pulse_R5: assert property (@(posedge clk) disable iff (!rstN)
    !strobeAcc |=> !pcLoad && $stable(pcTarget));

  assert_capture_R6: assert property (@(posedge clk) disable iff (!rstN)
    (autoEn && jmpTaken && !nibWrAcc) |=> addrReg == $past(retAddr));

  assert_hold_R7: assert property (@(posedge clk) disable iff (!rstN)
    (!nibWrAcc && !(autoEn && jmpTaken)) |=> $stable(addrReg));

  assert_priority_R8: assert property (@(posedge clk) disable iff (!rstN)
    (autoEn && jmpTaken && ioSel && ioWe && ioAddr == '0)
      |=> addrReg[NIB_W-1:0] == $past(ioWrData)
          && addrReg[ADDR_W-1:NIB_W] == $past(retAddr[ADDR_W-1:NIB_W]));
endmodule

bind link_port link_port_chk u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .ioSel    (ioSel),
  .ioWe     (ioWe),
  .ioAddr   (ioAddr),
  .ioWrData (ioWrData),
  .autoEn   (autoEn),
  .jmpTaken (jmpTaken),
  .retAddr  (retAddr),
  .pcLoad   (pcLoad),
  .pcTarget (pcTarget),
  .addrReg  (addrReg)
);

// File: tb/link_port_bench.sv
`timescale 1ns/1ps
module link_port_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN;
  logic        ioSel, ioWe;
  logic [1:0]  ioAddr;
  logic [3:0]  ioWrData;
  logic [3:0]  ioRdData;
  logic        autoEn, jmpTaken;
  logic [11:0] retAddr;
  logic        pcLoad;
  logic [11:0] pcTarget;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  link_port u_link_port (
    .clk(clk), .rstN(rstN), .ioSel(ioSel), .ioWe(ioWe), .ioAddr(ioAddr),
    .ioWrData(ioWrData), .ioRdData(ioRdData), .autoEn(autoEn),
    .jmpTaken(jmpTaken), .retAddr(retAddr), .pcLoad(pcLoad), .pcTarget(pcTarget)
  );

  task automatic check(input string tag, input logic [11:0] act, input logic [11:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic idle();
    ioSel = 0; ioWe = 0; ioAddr = 0; ioWrData = 0; jmpTaken = 0; retAddr = 0;
  endtask

  // Read the three nibbles through the read port (combinational, no edge)
  task automatic readAll(output logic [11:0] val);
    for (int k = 0; k < 3; k++) begin
      ioAddr = 2'(k); #1;
      val[k*4 +: 4] = ioRdData;
    end
    ioAddr = 0;
  endtask

  // Drive one access for one edge; returns at the following negedge
  task automatic access(input logic we, input logic [1:0] a, input logic [3:0] d);
    @(negedge clk); ioSel = 1; ioWe = we; ioAddr = a; ioWrData = d;
    @(negedge clk); idle();
  endtask

  task automatic writeAll(input logic [11:0] v);
    for (int k = 0; k < 3; k++) access(1'b1, 2'(k), v[k*4 +: 4]);
  endtask

  task automatic jump(input logic [11:0] ra);
    @(negedge clk); jmpTaken = 1; retAddr = ra;
    @(negedge clk); idle();
  endtask

  task automatic t_reset();
    logic [11:0] v;
    readAll(v);
    check("R1 nibbles", v, 12'h000);
    check("R1 pcLoad", {11'b0, pcLoad}, 12'h000);
    check("R1 pcTarget", pcTarget, 12'h000);
  endtask

  task automatic t_write();
    logic [11:0] v;
    writeAll(12'hCA5);
    readAll(v);
    check("R2 write nibbles", v, 12'hCA5);
    ioAddr = 2'd3; #1;
    check("R3 port3 reads zero", {8'b0, ioRdData}, 12'h000);
    access(1'b0, 2'd1, 4'h7);
    readAll(v);
    check("R3 read leaves nibbles", v, 12'hCA5);
  endtask

  task automatic t_strobe();
    logic [11:0] v;
    access(1'b0, 2'd3, 4'h0);
    check("R4 pulse after read strobe", {11'b0, pcLoad}, 12'h001);
    check("R4 target", pcTarget, 12'hCA5);
    @(negedge clk);
    check("R5 pulse one cycle", {11'b0, pcLoad}, 12'h000);
    check("R5 target holds", pcTarget, 12'hCA5);
    access(1'b1, 2'd3, 4'hF);
    check("R4 pulse after write strobe", {11'b0, pcLoad}, 12'h001);
    readAll(v);
    check("R4 port3 data ignored", v, 12'hCA5);
  endtask

  task automatic t_backToBack();
    writeAll(12'h123);
    @(negedge clk); ioSel = 1; ioWe = 0; ioAddr = 2'd3;
    @(negedge clk);
    check("R9 first pulse", {11'b0, pcLoad}, 12'h001);
    check("R9 target", pcTarget, 12'h123);
    @(negedge clk); idle();
    check("R9 second pulse", {11'b0, pcLoad}, 12'h001);
    @(negedge clk);
    check("R9 pulses end", {11'b0, pcLoad}, 12'h000);
  endtask

  task automatic t_capture();
    logic [11:0] v;
    autoEn = 1;
    jump(12'h3E7);
    readAll(v);
    check("R6 capture", v, 12'h3E7);
    jump(12'h456);
    readAll(v);
    check("R10 second capture replaces", v, 12'h456);
    access(1'b0, 2'd3, 4'h0);
    check("R10 return target", pcTarget, 12'h456);
  endtask

  task automatic t_disabled();
    logic [11:0] v;
    autoEn = 0;
    jump(12'hFFF);
    readAll(v);
    check("R7 no capture when off", v, 12'h456);
  endtask

  task automatic t_priority();
    logic [11:0] v;
    autoEn = 1;
    @(negedge clk);
    jmpTaken = 1; retAddr = 12'h777;
    ioSel = 1; ioWe = 1; ioAddr = 2'd1; ioWrData = 4'h2;
    @(negedge clk); idle();
    readAll(v);
    check("R8 write beats capture", v, 12'h727);
    autoEn = 0;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      nFails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  [TB] %0d tests run, %0d failed", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    rstN = 0; autoEn = 0; idle();
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    t_reset();
    t_write();
    t_strobe();
    t_backToBack();
    t_capture();
    t_disabled();
    t_priority();
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end
endmodule